// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small processor core that completes every instruction in one clock cycle. It has ten operations: four register-to-register arithmetic and logic operations, a signed set-on-less-than, an add-immediate, a word load, a word store, a branch on equality and an unconditional jump. Instruction fetch, decode, register read, ALU work, memory access and register write-back all happen in the same cycle. The program counter, the register file and the data memory update together on the rising clock edge.

The core has two memory ports, one for instructions and one for data. Instruction memory and data memory both read combinationally. The instruction port takes the current program counter as its address and returns the instruction word in the same cycle. The data port gives an address, write data and a write strobe, and returns read data combinationally. A store is committed by the memory on the clock edge while the strobe is high. Both memories are outside the core, and the testbench holds them as plain arrays.

Top module: `sc_risc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears all 32 registers to 0. After reset is released, the first instruction is fetched from address 0.
- R2: When the opcode (bits 31:26) is 000000, funct (bits 5:0) selects the operation on R[rs] and R[rt]. The codes are: 100000 add, 100010 subtract, 100100 AND, 100101 OR. The result is written to rd (bits 15:11). The source fields are rs (bits 25:21) and rt (bits 20:16).
- R3: Opcode 000000 with funct 101010 writes 1 to rd when R[rs] is less than R[rt] as two's-complement values, and writes 0 otherwise.
- R4: Opcode 001000 writes R[rs] plus the sign-extended bits 15:0 to rt.
- R5: For opcodes 100011 (load) and 101011 (store), the data address is R[rs] plus the sign-extended bits 15:0. A load writes the read data to rt. A store raises the write strobe for its single cycle and drives R[rt] as write data. No other instruction raises the strobe.
- R6: Opcode 000100 compares R[rs] with R[rt]. If they are equal, the next PC is PC+4 plus the sign-extended bits 15:0 shifted left by 2. Otherwise the next PC is PC+4.
- R7: Opcode 000010 sets the next PC to {upper 4 bits of PC+4, bits 25:0 of the instruction, 2'b00}.
- R8: Every instruction other than a taken branch or a jump advances the PC by 4 in one cycle.
- R9: Register 0 always reads as 0, and any write that targets it is discarded.
- R10: An opcode outside the set above, or a funct outside the set above when the opcode is 000000, writes no register and raises no strobe. It still advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch address (current program counter) |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Data to store |
| dmem_we | output | 1 | Store strobe, committed on the rising edge |
| dmem_rdata | input | 32 | Word read combinationally at dmem_addr |

## Verification
The main test program sums 0 through 9 with a counted loop. This exercises a forward taken branch, the same branch not taken while the loop runs, a backward jump, and a loop-carried register dependence. Signed arithmetic is tried with a negative immediate and mixed-sign comparisons: one operand order must give 1 and the reversed order must give 0, which separates a signed compare from an unsigned one. A store followed by a load through a negative offset checks that address formation sign-extends the offset. Writes aimed at register 0, an unknown opcode and an unknown funct are each followed by stores of the registers they could have changed. A second reset in the middle of the run, followed by a store of a register that was previously non-zero, shows whether the register file was cleared.

// File: rtl/sc_risc_core.sv
module sc_risc_core #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam int RW = $clog2(NREG);

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] regs [NREG];

  wire [5:0]    op     = imem_rdata[31:26];
  wire [5:0]    funct  = imem_rdata[5:0];
  wire [RW-1:0] src_a  = imem_rdata[21 +: RW];
  wire [RW-1:0] src_b  = imem_rdata[16 +: RW];
  wire [RW-1:0] dst_r  = imem_rdata[11 +: RW];

  wire [XLEN-1:0] imm_sx = {{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]};
  wire [XLEN-1:0] va     = (src_a == '0) ? '0 : regs[src_a];
  wire [XLEN-1:0] vb     = (src_b == '0) ? '0 : regs[src_b];
  wire [XLEN-1:0] ea     = va + imm_sx;
  wire            lt     = $signed(va) < $signed(vb);

  wire [XLEN-1:0] pc4    = pc + XLEN'(4);
  wire [XLEN-1:0] br_tgt = pc4 + {imm_sx[XLEN-3:0], 2'b00};
  wire [XLEN-1:0] jp_tgt = {pc4[XLEN-1:28], imem_rdata[25:0], 2'b00};

  logic            wb_en;
  logic [RW-1:0]   wb_dst;
  logic [XLEN-1:0] wb_data;
  logic [XLEN-1:0] pc_next;

  always_comb begin
    wb_en   = 1'b0;
    wb_dst  = src_b;
    wb_data = ea;
    case (op)
      OP_RTYPE: begin
        wb_dst = dst_r;
        wb_en  = 1'b1;
        case (funct)
          FN_ADD:  wb_data = va + vb;
          FN_SUB:  wb_data = va - vb;
          FN_AND:  wb_data = va & vb;
          FN_OR:   wb_data = va | vb;
          FN_SLT:  wb_data = {{(XLEN-1){1'b0}}, lt};
          default: wb_en = 1'b0;
        endcase
      end
      OP_ADDI: wb_en = 1'b1;
      OP_LOAD: begin
        wb_en   = 1'b1;
        wb_data = dmem_rdata;
      end
      default: ;
    endcase
  end

  always_comb begin
    pc_next = pc4;
    if (op == OP_JUMP)
      pc_next = jp_tgt;
    else if (op == OP_BEQ && va == vb)
      pc_next = br_tgt;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wb_en && wb_dst != '0) begin
      regs[wb_dst] <= wb_data;
    end
  end

  assign imem_addr  = pc;
  assign dmem_addr  = ea;
  assign dmem_wdata = vb;
  assign dmem_we    = (op == OP_STORE);

endmodule

// File: rtl/sc_risc_core_chk.sv
module sc_risc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_rdata,
  input logic        dmem_we
);
  wire [5:0]  op   = imem_rdata[31:26];
  wire [31:0] pc4  = imem_addr + 32'd4;
  wire [31:0] btgt = pc4 + {{14{imem_rdata[15]}}, imem_rdata[15:0], 2'b00};
  wire [31:0] jtgt = {pc4[31:28], imem_rdata[25:0], 2'b00};

  AST_PC_CLEARED: assert property (@(posedge clk) rst |=> imem_addr == 32'd0); // R1
  AST_STROBE_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> op == 6'b101011); // R5
  AST_BEQ_TARGET: assert property (@(posedge clk) disable iff (rst)
    op == 6'b000100 |=> (imem_addr == $past(pc4) || imem_addr == $past(btgt))); // R6
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    op == 6'b000010 |=> imem_addr == $past(jtgt)); // R7
  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (op != 6'b000100 && op != 6'b000010) |=> imem_addr == $past(pc4)); // R8
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    imem_addr[1:0] == 2'b00); // R8
endmodule

bind sc_risc_core sc_risc_core_chk u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr),
  .imem_rdata(imem_rdata), .dmem_we(dmem_we)
);

// File: tb/sc_risc_core_tb.sv
`timescale 1ns/1ps
module sc_risc_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  sc_risc_core u_dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  // reference model state
  logic [31:0] m_pc;
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [64];
  string       m_tag [32];
  string       pc_tag;

  function automatic logic [31:0] rt_op(input int fn, input int rd, input int rs, input int rt);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] it_op(input int op, input int rt, input int rs, input int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = 0;
    pc_tag = "R1";
    for (int i = 0; i < 32; i++) begin
      m_reg[i] = 0;
      m_tag[i] = "R1";
    end
  endtask

  task automatic model_step();
    logic [31:0] ins, a, b, imm, nxt, ea;
    int op, fn, rs, rt, rd;
    bit exp_we;
    ins = imem[m_pc[7:2]];
    op = int'(ins[31:26]); fn = int'(ins[5:0]);
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    a = m_reg[rs]; b = m_reg[rt];
    imm = {{16{ins[15]}}, ins[15:0]};
    ea = a + imm;
    check(imem_addr === m_pc, pc_tag, "fetch address", imem_addr, m_pc);
    exp_we = (op == 43);
    check(dmem_we === exp_we, "R5", "store strobe", {31'd0, dmem_we}, {31'd0, exp_we});
    if (exp_we) begin
      check(dmem_addr === ea, "R5", "store address", dmem_addr, ea);
      check(dmem_wdata === b, m_tag[rt], "store data", dmem_wdata, b);
      m_mem[ea[7:2]] = b;
    end
    nxt = m_pc + 4;
    pc_tag = "R8";
    case (op)
      0: begin
        logic [31:0] r;
        bit known = 1'b1;
        string t = "R2";
        case (fn)
          32: r = a + b;
          34: r = a - b;
          36: r = a & b;
          37: r = a | b;
          42: begin r = ($signed(a) < $signed(b)) ? 1 : 0; t = "R3"; end
          default: begin known = 1'b0; r = 0; end
        endcase
        if (!known) m_tag[rd] = "R10";
        else if (rd == 0) m_tag[0] = "R9";
        else begin m_reg[rd] = r; m_tag[rd] = t; end
      end
      8:  if (rt == 0) m_tag[0] = "R9"; else begin m_reg[rt] = ea; m_tag[rt] = "R4"; end
      35: if (rt == 0) m_tag[0] = "R9"; else begin m_reg[rt] = m_mem[ea[7:2]]; m_tag[rt] = "R5"; end
      43: ;
      4:  begin
            pc_tag = "R6";
            if (a == b) nxt = m_pc + 4 + (imm << 2);
          end
      2:  begin
            pc_tag = "R7";
            nxt = {nxt[31:28], ins[25:0], 2'b00};
          end
      default: m_tag[rt] = "R10";
    endcase
    m_pc = nxt;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'd0;
      dmem[i] = 32'd0;
      m_mem[i] = 32'd0;
    end
    imem[0]  = it_op(43, 17, 0, 'h40);
    imem[1]  = it_op(8, 17, 0, 0);
    imem[2]  = rt_op(32, 16, 0, 0);
    imem[3]  = it_op(8, 8, 0, 10);
    imem[4]  = it_op(4, 8, 16, 3);
    imem[5]  = rt_op(32, 17, 17, 16);
    imem[6]  = it_op(8, 16, 16, 1);
    imem[7]  = {6'd2, 26'd4};
    imem[8]  = it_op(43, 17, 0, 'h44);
    imem[9]  = it_op(8, 9, 0, -5);
    imem[10] = rt_op(42, 10, 9, 8);
    imem[11] = rt_op(42, 11, 8, 9);
    imem[12] = rt_op(34, 12, 9, 8);
    imem[13] = rt_op(36, 13, 12, 8);
    imem[14] = rt_op(37, 14, 12, 8);
    imem[15] = it_op(8, 0, 0, 7);
    imem[16] = rt_op(32, 0, 8, 8);
    imem[17] = it_op(8, 15, 0, 'h80);
    imem[18] = it_op(43, 9, 15, -8);
    imem[19] = it_op(35, 18, 15, -8);
    imem[20] = {6'h3F, 5'd0, 5'd19, 16'h1234};
    imem[21] = rt_op(0, 20, 8, 8);
    imem[22] = it_op(4, 8, 9, 5);
    imem[23] = it_op(43, 0, 0, 'h48);
    imem[24] = it_op(43, 10, 0, 'h4C);
    imem[25] = it_op(43, 11, 0, 'h50);
    imem[26] = it_op(43, 12, 0, 'h54);
    imem[27] = it_op(43, 13, 0, 'h58);
    imem[28] = it_op(43, 14, 0, 'h5C);
    imem[29] = it_op(43, 18, 0, 'h60);
    imem[30] = it_op(43, 19, 0, 'h64);
    imem[31] = it_op(43, 20, 0, 'h68);
    imem[32] = it_op(4, 0, 0, -1);

    for (int pass = 0; pass < 2; pass++) begin
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(imem_addr === 32'd0, "R1", "pc after reset", imem_addr, 32'd0);
      model_reset();
      rst = 1'b0;
      for (int c = 0; c < 150; c++) begin
        model_step();
        @(negedge clk);
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule